// File: doc/BRIEF.md
# Super-IO Configuration Unlock Port

This block puts a small configuration register space behind a pair of byte-wide I/O ports. The index port sits at offset 0 and the data port at offset 1. After reset the space is hidden. Software opens it by writing a key byte to the index port twice in succession. Once the space is open, software writes a register number to the index port and then reads or writes that register through the data port. Writing the seal byte 0xAA to the index port hides the space again.

The register space holds three fixed identification bytes and a bank of read/write scratch registers. A probe can read the identification locations before and after unlocking and compare the results. The results differ because a hidden space never returns identification values. The open state is exported on `unlocked_o` for neighbouring logic.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is hidden (`unlocked_o`=0) and the index register holds 0x00. After the first unlock, a data read without any index write returns 0x00.
- R2: While hidden, two consecutive index-port writes of KEY (default 0x87) open the space. `unlocked_o` rises in the cycle after the clock edge that captures the second write. Reads and data-port writes between the two keys do not break the sequence.
- R3: While hidden, a single KEY write does not open the space. An index write of any other value between the two keys restarts the sequence.
- R4: While open, an index-port write of 0xAA hides the space from the next cycle and clears the index register.
- R5: While hidden, a read of either port returns 0xFF.
- R6: While hidden, a data-port write changes no register.
- R7: While open, an index write of any value other than 0xAA loads the index register and leaves the space open. An index-port read then returns the index.
- R8: While open, a data read at index 0x20 returns DEV_ID (default 0xA3). Index 0x21 returns DEV_REV (default 0x14), and index 0x09 returns LEGACY_ID (default 0x6C).
- R9: While open, indexes 0x30 to 0x3F are read/write scratch registers through the data port. Every other index reads 0x00, and data writes to those indexes are dropped.
- R10: `rdata_o` is 0x00 whenever `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_i | input | 1 | I/O write strobe, one cycle per access |
| rd_i | input | 1 | I/O read strobe |
| addr_i | input | 1 | port select: 0 index, 1 data |
| wdata_i | input | 8 | write data |
| rdata_o | output | 8 | read data, combinational on rd_i |
| unlocked_o | output | 1 | configuration space is open |

## Verification
The assertions assume that `wr_i` and `rd_i` are never high in the same cycle. They also assume that each high cycle of `wr_i` is exactly one access. The bench follows both rules: every access is a one-cycle strobe driven on the falling edge and released one cycle later.

Random traffic gives key, seal, identification and scratch index values a large share of the index writes. The sequencer therefore opens and closes many times, and the scratch bank is written both while open and while hidden.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;
  localparam logic [7:0] SEAL_BYTE  = 8'hAA;
  localparam logic [7:0] IDX_DEVID  = 8'h20;
  localparam logic [7:0] IDX_DEVREV = 8'h21;
  localparam logic [7:0] IDX_LEGACY = 8'h09;
  localparam logic [7:0] HIDDEN_RD  = 8'hFF;

  typedef enum logic [1:0] {
    ST_HIDDEN = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } cfg_state_e;
endpackage

// File: rtl/sio_cfg_unlock.sv
`timescale 1ns/1ps
module sio_cfg_unlock
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] KEY = 8'h87
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic       seal_o
);
  cfg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        ST_HIDDEN: state_d = (wdata_i == KEY) ? ST_ARMED : ST_HIDDEN;
        ST_ARMED:  state_d = (wdata_i == KEY) ? ST_OPEN  : ST_HIDDEN;
        ST_OPEN:   state_d = (wdata_i == SEAL_BYTE) ? ST_HIDDEN : ST_OPEN;
        default:   state_d = ST_HIDDEN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HIDDEN;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == ST_OPEN);
  assign seal_o = open_o && idx_wr_i && (wdata_i == SEAL_BYTE);
endmodule

// File: rtl/sio_cfg_regs.sv
`timescale 1ns/1ps
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ID    = 8'hA3,
  parameter logic [7:0] DEV_REV   = 8'h14,
  parameter logic [7:0] LEGACY_ID = 8'h6C,
  parameter int unsigned SCR_BASE = 8'h30,
  parameter int unsigned SCR_N    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       open_i,
  input  logic       seal_i,
  input  logic       idx_wr_i,
  input  logic       dat_wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] index_o,
  output logic [7:0] data_o
);
  localparam int unsigned SCR_W   = (SCR_N > 1) ? $clog2(SCR_N) : 1;
  localparam int unsigned SCR_END = SCR_BASE + SCR_N;

  logic [7:0]       index_q;
  logic [7:0]       scr_q [SCR_N];
  logic             scr_hit;
  logic [SCR_W-1:0] scr_off;
  logic [8:0]       idx_rel;

  // index register: loads only while open, cleared by seal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           index_q <= 8'h00;
    else if (seal_i)                       index_q <= 8'h00;
    else if (open_i && idx_wr_i)           index_q <= wdata_i;
  end

  assign idx_rel = {1'b0, index_q} - 9'(SCR_BASE);
  assign scr_hit = ({1'b0, index_q} >= 9'(SCR_BASE)) && ({1'b0, index_q} < 9'(SCR_END));
  assign scr_off = idx_rel[SCR_W-1:0];

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        scr_q[g] <= 8'h00;
      else if (open_i && dat_wr_i && scr_hit && scr_off == SCR_W'(g))
        scr_q[g] <= wdata_i;
    end
  end

  always_comb begin
    unique case (index_q)
      IDX_DEVID:  data_o = DEV_ID;
      IDX_DEVREV: data_o = DEV_REV;
      IDX_LEGACY: data_o = LEGACY_ID;
      default:    data_o = scr_hit ? scr_q[scr_off] : 8'h00;
    endcase
  end

  assign index_o = index_q;
endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] KEY       = 8'h87,
  parameter logic [7:0] DEV_ID    = 8'hA3,
  parameter logic [7:0] DEV_REV   = 8'h14,
  parameter logic [7:0] LEGACY_ID = 8'h6C,
  parameter int unsigned SCR_BASE = 8'h30,
  parameter int unsigned SCR_N    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       unlocked_o
);
  logic       idx_wr, dat_wr, open, seal;
  logic [7:0] index_val, data_val, port_val;

  assign idx_wr = wr_i && !addr_i;
  assign dat_wr = wr_i &&  addr_i;

  sio_cfg_unlock #(.KEY(KEY)) u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (idx_wr),
    .wdata_i  (wdata_i),
    .open_o   (open),
    .seal_o   (seal)
  );

  sio_cfg_regs #(
    .DEV_ID   (DEV_ID),
    .DEV_REV  (DEV_REV),
    .LEGACY_ID(LEGACY_ID),
    .SCR_BASE (SCR_BASE),
    .SCR_N    (SCR_N)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (open),
    .seal_i   (seal),
    .idx_wr_i (idx_wr),
    .dat_wr_i (dat_wr),
    .wdata_i  (wdata_i),
    .index_o  (index_val),
    .data_o   (data_val)
  );

  always_comb begin
    if (!open)       port_val = HIDDEN_RD;
    else if (addr_i) port_val = data_val;
    else             port_val = index_val;
  end

  assign rdata_o    = rd_i ? port_val : 8'h00;
  assign unlocked_o = open;
endmodule

// File: rtl/sio_cfg_port_chk.sv
`timescale 1ns/1ps
module sio_cfg_port_chk #(
  parameter logic [7:0] KEY = 8'h87
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       unlocked_o
);
  a_r5_hidden_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && rd_i) |-> rdata_o == 8'hFF);

  a_r4_seal_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && wr_i && !addr_i && wdata_i == 8'hAA) |=> !unlocked_o);

  a_r2_open_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(wr_i && !addr_i && wdata_i == KEY));

  a_r7_open_holds_without_seal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && !(wr_i && !addr_i && wdata_i == 8'hAA)) |=> unlocked_o);

  a_r3_state_moves_only_on_index_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !addr_i) |=> $stable(unlocked_o));

  a_r10_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.KEY(KEY)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .unlocked_o(unlocked_o)
);

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;
  localparam logic [7:0] KEY = 8'h87;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       unlocked_o;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  bit         m_open = 0, m_armed = 0;
  logic [7:0] m_idx = 8'h00;
  logic [7:0] m_scr [16];

  always #10 clk_i = ~clk_i;

  sio_cfg_port #(.KEY(KEY)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .unlocked_o(unlocked_o)
  );

  function automatic logic [7:0] exp_read(input logic a);
    if (!m_open) return 8'hFF;
    if (!a) return m_idx;
    case (m_idx)
      8'h20: return 8'hA3;
      8'h21: return 8'h14;
      8'h09: return 8'h6C;
      default: return (m_idx >= 8'h30 && m_idx <= 8'h3F) ? m_scr[m_idx[3:0]] : 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic a, input logic [7:0] d);
    if (!a) begin
      if (!m_open) begin
        if (d == KEY) begin
          if (m_armed) begin m_open = 1; m_armed = 0; end
          else m_armed = 1;
        end else m_armed = 0;
      end else if (d == 8'hAA) begin
        m_open = 0; m_idx = 8'h00;
      end else m_idx = d;
    end else if (m_open && m_idx >= 8'h30 && m_idx <= 8'h3F) begin
      m_scr[m_idx[3:0]] = d;
    end
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 0;
    model_wr(a, d);
  endtask

  task automatic io_rd(input string req, input logic a);
    @(negedge clk_i);
    rd_i = 1; addr_i = a;
    #5 chk(req, rdata_o, exp_read(a));
    @(negedge clk_i);
    rd_i = 0;
  endtask

  task automatic chk_open(input string req);
    #1 chk(req, {7'd0, unlocked_o}, {7'd0, m_open});
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_scr[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 / R10 reset state
    chk_open("R1");
    #1 chk("R10", rdata_o, 8'h00);
    io_rd("R5", 1'b1);
    io_rd("R5", 1'b0);

    // R3 single key, broken sequence
    io_wr(0, KEY);           chk_open("R3");
    io_rd("R3", 1'b1);
    io_wr(0, 8'h20);
    io_wr(0, KEY);           chk_open("R3");
    io_wr(0, 8'h11);         chk_open("R3");

    // R2 keys with a read and a data write between them
    io_wr(0, KEY);
    io_rd("R5", 1'b1);
    io_wr(1, 8'h5C);
    io_wr(0, KEY);           chk_open("R2");
    io_rd("R1", 1'b1);       // index still 0x00

    // R8 identification
    io_wr(0, 8'h20); io_rd("R8", 1'b1);
    io_wr(0, 8'h21); io_rd("R8", 1'b1);
    io_wr(0, 8'h09); io_rd("R8", 1'b1);

    // R9 scratch and unmapped
    io_wr(0, 8'h35); io_wr(1, 8'h5A); io_rd("R9", 1'b1);
    io_wr(0, 8'h3F); io_wr(1, 8'hC3); io_rd("R9", 1'b1);
    io_wr(0, 8'h40); io_wr(1, 8'h11); io_rd("R9", 1'b1);
    io_wr(0, 8'h2F); io_wr(1, 8'h22); io_rd("R9", 1'b1);

    // R7 index readback, still open, key value as index
    io_wr(0, KEY);           chk_open("R7");
    io_rd("R7", 1'b0);

    // R4 seal, R6 hidden data write
    io_wr(0, 8'h35);
    io_wr(0, 8'hAA);         chk_open("R4");
    io_wr(1, 8'h77);
    io_rd("R5", 1'b1);
    io_wr(0, KEY); io_wr(0, KEY); chk_open("R2");
    io_rd("R4", 1'b0);       // index cleared by seal
    io_wr(0, 8'h35); io_rd("R6", 1'b1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned op;
      logic [7:0] v;
      op = $urandom_range(0, 9);
      if (op < 5) begin
        case ($urandom_range(0, 6))
          0, 1: v = KEY;
          2:    v = 8'hAA;
          3:    v = 8'h20 + 8'($urandom_range(0, 1));
          4:    v = 8'h09;
          5:    v = 8'h30 + 8'($urandom_range(0, 15));
          default: v = 8'($urandom);
        endcase
        io_wr(0, v);
        chk_open("R2");
      end else if (op < 7) begin
        io_wr(1, 8'($urandom));
        chk_open("R6");
      end else begin
        io_rd("R9", op[0]);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule